// File: doc/BRIEF.md
# DRAM Refresh Sequencing Controller

This block keeps the contents of an asynchronous DRAM array alive by issuing one refresh cycle per fixed interval. A down-counting interval timer, sized from the clock frequency and the required per-row refresh period, raises a refresh request. A small sequencer waits until the host-access logic reports that the memory bus is free. It then raises a busy flag, which keeps the host side from starting a cycle, and drives the row and column strobes through a setup, an active and a precharge phase. The minimum length of each phase is set by a parameter.

Two refresh styles are supported and chosen by an input. In row-addressed refresh, the controller places its own row counter on the multiplexed address lines and pulses the row strobe while the column strobe stays high. The counter then advances and wraps. In column-first refresh, the column strobe falls a set number of cycles before the row strobe, and the device uses its internal row counter. The controller therefore leaves the address lines undriven. A request that expires while the bus is busy is kept pending, and repeated expiries merge into that single pending request.

Top module: `dram_refresh_ctrl`

## Requirements
- R1: While reset is high and after reset: ras_n=1, cas_n=1, refresh_busy=0, addr_oe=0 and addr=0. The row counter restarts at 0 and the interval timer restarts from its full count.
- R2: With bus_idle held at 1, refresh_busy first rises at the INTERVAL-th rising clock edge after reset is released, and rises again every INTERVAL cycles. INTERVAL = CLK_MHZ*REFRESH_NS/1000.
- R3: No refresh cycle starts while bus_idle=0. Once refresh_busy is low, ras_n and cas_n stay 1 and addr_oe stays 0.
- R4: Any number of interval expiries while bus_idle=0 yield exactly one refresh cycle. That cycle starts at the first clock edge at which bus_idle=1.
- R5: refresh_busy stays 1 for the whole refresh cycle, including precharge. Its length is the setup time + T_RAS + T_RP cycles, where the setup time is T_ASR in row-addressed mode and T_CSR in column-first mode.
- R6: Row-addressed mode (mode_cbr=0): addr_oe=1 with addr equal to the row counter for T_ASR cycles, then during T_RAS cycles with ras_n=0. cas_n stays 1 for the whole cycle.
- R7: The row counter advances by one after each row-addressed refresh and wraps from 2^ROW_BITS-1 to 0. A column-first refresh leaves it unchanged.
- R8: Column-first mode (mode_cbr=1): cas_n goes low T_CSR cycles before ras_n. Both strobes are then low for T_RAS cycles, and addr_oe stays 0 throughout.
- R9: After ras_n rises, both strobes stay high for T_RP cycles before refresh_busy falls.
- R10: mode_cbr is sampled when a cycle starts. Changing it while refresh_busy=1 does not alter the cycle in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_cbr | input | 1 | 0: row-addressed refresh, 1: column-first refresh |
| bus_idle | input | 1 | High when no host access is in progress |
| refresh_busy | output | 1 | High while a refresh cycle owns the bus |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| addr_oe | output | 1 | High when addr carries a valid row address |
| addr | output | ROW_BITS | Multiplexed row address (0 when not driven) |

## Verification
An interval expiry can land in the same cycle as a bus-busy period, or while a refresh cycle is still running. The pending-request logic and the start decision therefore meet in one clock. To provoke this, bus_idle is held low across three consecutive expiries and released two cycles after the last one. The check is that exactly one cycle follows, at the first idle edge, and that no second cycle follows before the next expiry. A mode change is also made in the middle of a refresh cycle, which tests the sampling of mode_cbr against the phase sequencing. The waveform is judged against the mode that was in force when the cycle started.

// File: rtl/drfr_pkg.sv
package drfr_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'd0,
        SEQ_SETUP  = 2'd1,
        SEQ_ACTIVE = 2'd2,
        SEQ_PRECH  = 2'd3
    } seq_state_e;

    typedef enum logic {
        REF_ROW_ADDR = 1'b0,
        REF_CAS_FIRST = 1'b1
    } ref_mode_e;

    typedef struct packed {
        logic ras_n;
        logic cas_n;
        logic addr_oe;
        logic busy;
    } strobe_t;

    function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    function automatic int unsigned setup_cycles(input ref_mode_e m,
                                                 input int unsigned t_asr,
                                                 input int unsigned t_csr);
        return (m == REF_CAS_FIRST) ? t_csr : t_asr;
    endfunction

    function automatic strobe_t strobe_decode(input seq_state_e st, input ref_mode_e m);
        strobe_t s;
        s.ras_n   = 1'b1;
        s.cas_n   = 1'b1;
        s.addr_oe = 1'b0;
        s.busy    = (st != SEQ_IDLE);
        case (st)
            SEQ_SETUP: begin
                if (m == REF_CAS_FIRST) s.cas_n = 1'b0;
                else                    s.addr_oe = 1'b1;
            end
            SEQ_ACTIVE: begin
                s.ras_n = 1'b0;
                if (m == REF_CAS_FIRST) s.cas_n = 1'b0;
                else                    s.addr_oe = 1'b1;
            end
            default: ;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/drfr_interval_timer.sv
module drfr_interval_timer #(
    parameter int unsigned INTERVAL = 4000
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int unsigned CW = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;
    localparam logic [CW-1:0] RELOAD = CW'(INTERVAL - 1);

    logic [CW-1:0] cnt_q;

    assign tick = (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= RELOAD;
        end else if (tick) begin
            cnt_q <= RELOAD;
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    AST_TIMER_RANGE: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= RELOAD); // R2

    AST_TIMER_DESCENDS: assert property (@(posedge clk) disable iff (rst)
        (cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R2

endmodule

// File: rtl/drfr_row_counter.sv
module drfr_row_counter #(
    parameter int unsigned ROW_BITS = 10
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                step,
    output logic [ROW_BITS-1:0] row
);
    localparam logic [ROW_BITS-1:0] ROW_LAST = {ROW_BITS{1'b1}};

    logic [ROW_BITS-1:0] row_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            row_q <= '0;
        end else if (step) begin
            row_q <= (row_q == ROW_LAST) ? '0 : row_q + 1'b1;
        end
    end

    assign row = row_q;

    AST_ROW_SINGLE_STEP: assert property (@(posedge clk) disable iff (rst)
        (row_q != $past(row_q)) |->
        (row_q == (($past(row_q) == ROW_LAST) ? '0 : $past(row_q) + 1'b1))); // R7

    AST_ROW_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(row_q)); // R7

endmodule

// File: rtl/drfr_sequencer.sv
module drfr_sequencer
    import drfr_pkg::*;
#(
    parameter int unsigned ROW_BITS = 10,
    parameter int unsigned T_ASR    = 1,
    parameter int unsigned T_CSR    = 2,
    parameter int unsigned T_RAS    = 4,
    parameter int unsigned T_RP     = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                mode_in,
    input  logic                bus_idle,
    input  logic                tick,
    input  logic [ROW_BITS-1:0] row_in,
    output logic                row_step,
    output logic                busy,
    output logic                ras_n,
    output logic                cas_n,
    output logic                addr_oe,
    output logic [ROW_BITS-1:0] addr
);
    localparam int unsigned PH_MAX = max3(max3(T_ASR, T_CSR, 1), T_RAS, T_RP);
    localparam int unsigned PW     = (PH_MAX > 1) ? $clog2(PH_MAX) : 1;

    seq_state_e    state_q;
    ref_mode_e     mode_q;
    logic          pending_q;
    logic [PW-1:0] ph_q;
    logic          start;
    logic          ph_done;
    strobe_t       sig;
    ref_mode_e     mode_sel;

    assign mode_sel = mode_in ? REF_CAS_FIRST : REF_ROW_ADDR;
    assign start    = (state_q == SEQ_IDLE) && (pending_q || tick) && bus_idle;
    assign ph_done  = (ph_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= SEQ_IDLE;
            mode_q    <= REF_ROW_ADDR;
            pending_q <= 1'b0;
            ph_q      <= '0;
        end else begin
            pending_q <= (pending_q || tick) && !start;
            case (state_q)
                SEQ_IDLE: begin
                    if (start) begin
                        mode_q  <= mode_sel;
                        state_q <= SEQ_SETUP;
                        ph_q    <= PW'(setup_cycles(mode_sel, T_ASR, T_CSR) - 1);
                    end
                end
                SEQ_SETUP: begin
                    if (ph_done) begin
                        state_q <= SEQ_ACTIVE;
                        ph_q    <= PW'(T_RAS - 1);
                    end else begin
                        ph_q <= ph_q - 1'b1;
                    end
                end
                SEQ_ACTIVE: begin
                    if (ph_done) begin
                        state_q <= SEQ_PRECH;
                        ph_q    <= PW'(T_RP - 1);
                    end else begin
                        ph_q <= ph_q - 1'b1;
                    end
                end
                default: begin
                    if (ph_done) begin
                        state_q <= SEQ_IDLE;
                    end else begin
                        ph_q <= ph_q - 1'b1;
                    end
                end
            endcase
        end
    end

    assign row_step = (state_q == SEQ_ACTIVE) && ph_done && (mode_q == REF_ROW_ADDR);

    always_comb begin
        sig = strobe_decode(state_q, mode_q);
    end

    assign busy    = sig.busy;
    assign ras_n   = sig.ras_n;
    assign cas_n   = sig.cas_n;
    assign addr_oe = sig.addr_oe;
    assign addr    = sig.addr_oe ? row_in : '0;

    AST_STROBES_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (ras_n && cas_n && !addr_oe)); // R3

    AST_START_NEEDS_IDLE: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(bus_idle)); // R3

    AST_PENDING_KEPT: assert property (@(posedge clk) disable iff (rst)
        (pending_q && !bus_idle) |=> pending_q); // R4

    AST_ADDR_ONLY_CAS_HIGH: assert property (@(posedge clk) disable iff (rst)
        addr_oe |-> cas_n); // R6

    AST_CAS_LEADS_RAS: assert property (@(posedge clk) disable iff (rst)
        $fell(cas_n) |-> ras_n); // R8

    AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(mode_q)); // R10

    AST_BUSY_COVERS_RAS: assert property (@(posedge clk) disable iff (rst)
        $rose(ras_n) |-> busy); // R9

endmodule

// File: rtl/dram_refresh_ctrl.sv
module dram_refresh_ctrl #(
    parameter int unsigned ROW_BITS   = 10,
    parameter int unsigned CLK_MHZ    = 250,
    parameter int unsigned REFRESH_NS = 16000,
    parameter int unsigned T_ASR      = 1,
    parameter int unsigned T_CSR      = 2,
    parameter int unsigned T_RAS      = 4,
    parameter int unsigned T_RP       = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                mode_cbr,
    input  logic                bus_idle,
    output logic                refresh_busy,
    output logic                ras_n,
    output logic                cas_n,
    output logic                addr_oe,
    output logic [ROW_BITS-1:0] addr
);
    localparam int unsigned INTERVAL = (CLK_MHZ * REFRESH_NS) / 1000;

    logic                tick;
    logic                row_step;
    logic [ROW_BITS-1:0] row;

    drfr_interval_timer #(
        .INTERVAL (INTERVAL)
    ) u_timer (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    drfr_row_counter #(
        .ROW_BITS (ROW_BITS)
    ) u_rows (
        .clk  (clk),
        .rst  (rst),
        .step (row_step),
        .row  (row)
    );

    drfr_sequencer #(
        .ROW_BITS (ROW_BITS),
        .T_ASR    (T_ASR),
        .T_CSR    (T_CSR),
        .T_RAS    (T_RAS),
        .T_RP     (T_RP)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .mode_in  (mode_cbr),
        .bus_idle (bus_idle),
        .tick     (tick),
        .row_in   (row),
        .row_step (row_step),
        .busy     (refresh_busy),
        .ras_n    (ras_n),
        .cas_n    (cas_n),
        .addr_oe  (addr_oe),
        .addr     (addr)
    );

endmodule

// File: tb/dram_refresh_ctrl_bench.sv
`timescale 1ns/1ps
module dram_refresh_ctrl_bench;
    localparam int RB    = 10;
    localparam int IV    = 20;
    localparam int TASR  = 1;
    localparam int TCSR  = 2;
    localparam int TRAS  = 4;
    localparam int TRP   = 3;
    localparam int NROWS = 1 << RB;

    typedef struct packed {
        logic       mode;
        logic       flip;
        logic [7:0] ras_low;
        logic [7:0] cas_lead;
        logic [7:0] busy_len;
        logic       oe;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{1'b0, 1'b0, 8'(TRAS), 8'd0,    8'(TASR+TRAS+TRP), 1'b1},
        '{1'b1, 1'b0, 8'(TRAS), 8'(TCSR), 8'(TCSR+TRAS+TRP), 1'b0},
        '{1'b0, 1'b0, 8'(TRAS), 8'd0,    8'(TASR+TRAS+TRP), 1'b1},
        '{1'b0, 1'b1, 8'(TRAS), 8'd0,    8'(TASR+TRAS+TRP), 1'b1},
        '{1'b1, 1'b1, 8'(TRAS), 8'(TCSR), 8'(TCSR+TRAS+TRP), 1'b0},
        '{1'b0, 1'b0, 8'(TRAS), 8'd0,    8'(TASR+TRAS+TRP), 1'b1}
    };

    logic          clk = 1'b0;
    logic          rst;
    logic          mode_cbr;
    logic          bus_idle;
    logic          refresh_busy;
    logic          ras_n;
    logic          cas_n;
    logic          addr_oe;
    logic [RB-1:0] addr;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int prev_rise = -1;
    int exp_row = 0;
    bit done = 0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    dram_refresh_ctrl #(
        .ROW_BITS (RB), .CLK_MHZ (250), .REFRESH_NS (80),
        .T_ASR (TASR), .T_CSR (TCSR), .T_RAS (TRAS), .T_RP (TRP)
    ) u_dram_refresh_ctrl (
        .clk (clk), .rst (rst), .mode_cbr (mode_cbr), .bus_idle (bus_idle),
        .refresh_busy (refresh_busy), .ras_n (ras_n), .cas_n (cas_n),
        .addr_oe (addr_oe), .addr (addr)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_busy();
        while (!refresh_busy) @(negedge clk);
    endtask

    task automatic run_vec(input vec_t v, input bit check_period);
        int ras_cnt = 0, lead = 0, prech = 0, blen = 0, a = -1;
        bit cas_bad = 0, oe_bad = 0;
        mode_cbr = v.mode;
        wait_busy();
        if (check_period) chk("R2 period", cyc - prev_rise, IV);
        prev_rise = cyc;
        if (!v.mode) chk("R6 setup addr_oe", int'(addr_oe), 1);
        while (refresh_busy) begin
            blen++;
            if (!ras_n) begin
                if (ras_cnt == 0) a = int'(addr);
                ras_cnt++;
                if (addr_oe != v.oe) oe_bad = 1;
            end else if (ras_cnt == 0 && !cas_n) begin
                lead++;
            end else if (ras_cnt > 0 && cas_n) begin
                prech++;
            end
            if (!v.mode && !cas_n) cas_bad = 1;
            if (v.flip && blen == 2) mode_cbr = !v.mode;
            @(negedge clk);
        end
        chk(v.flip ? "R10 ras low" : "R6 R8 ras low", ras_cnt, int'(v.ras_low));
        chk(v.flip ? "R10 cas lead" : "R8 cas lead", lead, int'(v.cas_lead));
        chk("R5 busy length", blen, int'(v.busy_len));
        chk("R9 precharge", prech, TRP);
        chk("R6 R8 addr_oe during ras", int'(oe_bad), 0);
        chk("R6 cas stays high", int'(cas_bad), 0);
        if (!v.mode) begin
            chk("R7 row address", a, exp_row);
            exp_row = (exp_row + 1) % NROWS;
        end
    endtask

    task automatic check_reset_outputs();
        chk("R1 ras_n", int'(ras_n), 1);
        chk("R1 cas_n", int'(cas_n), 1);
        chk("R1 busy", int'(refresh_busy), 0);
        chk("R1 addr_oe", int'(addr_oe), 0);
        chk("R1 addr", int'(addr), 0);
    endtask

    initial begin
        #600000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int rel, t0, rises, errs;
        bit prev_b, saw_wrap;
        rst = 1'b1;
        mode_cbr = 1'b0;
        bus_idle = 1'b1;
        repeat (4) @(negedge clk);
        check_reset_outputs();
        rst = 1'b0;
        rel = cyc;
        wait_busy();
        chk("R1 R2 first start", cyc - rel, IV);

        // vector table walk
        for (int i = 0; i < 6; i++) begin
            run_vec(VECS[i], i > 0);
        end

        // merged expiries while the bus is busy (R3, R4)
        mode_cbr = 1'b1;
        wait_busy();
        t0 = cyc;
        bus_idle = 1'b0;
        rises = 0;
        errs = 0;
        prev_b = 1'b1;
        while (cyc - t0 < 3 * IV + 2) begin
            @(negedge clk);
            if (refresh_busy && !prev_b) rises++;
            if (!refresh_busy && (!ras_n || !cas_n || addr_oe)) errs++;
            prev_b = refresh_busy;
        end
        chk("R3 no start while bus busy", rises, 0);
        chk("R3 strobes quiet", errs, 0);
        bus_idle = 1'b1;
        @(negedge clk);
        chk("R4 start on first idle edge", int'(refresh_busy), 1);
        rises = refresh_busy ? 1 : 0;
        prev_b = refresh_busy;
        for (int k = 1; k < IV - 4; k++) begin
            @(negedge clk);
            if (refresh_busy && !prev_b) rises++;
            prev_b = refresh_busy;
        end
        chk("R4 single merged refresh", rises, 1);

        // sweep all rows in row-addressed mode, CBR must not have advanced (R7)
        while (refresh_busy) @(negedge clk);
        mode_cbr = 1'b0;
        errs = 0;
        saw_wrap = 0;
        for (int k = 0; k < NROWS + 4; k++) begin
            int prev_row;
            while (ras_n) @(negedge clk);
            if (k == 0) chk("R7 CBR leaves row", int'(addr), exp_row);
            if (int'(addr) != exp_row) errs++;
            prev_row = exp_row;
            if (prev_row == NROWS - 1 && k + 1 < NROWS + 4) saw_wrap = 1;
            exp_row = (exp_row + 1) % NROWS;
            while (refresh_busy) @(negedge clk);
        end
        chk("R7 row sweep mismatches", errs, 0);
        chk("R7 wrap reached", int'(saw_wrap), 1);
        wait_busy();
        while (ras_n) @(negedge clk);
        chk("R7 after wrap row", int'(addr), exp_row);

        // reset in the middle of a cycle (R1)
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check_reset_outputs();
        repeat (2) @(negedge clk);
        rst = 1'b0;
        rel = cyc;
        exp_row = 0;
        wait_busy();
        chk("R1 timer restarts", cyc - rel, IV);
        run_vec(VECS[0], 1'b0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule